// File: doc/BRIEF.md
# Fanout-Split Logarithmic Shift Unit

This block shifts an N-bit word in one of three modes: rotate, logical shift, or arithmetic shift. Each mode can shift right or left. A single logarithmic rotator does all of the work. It has log2(N) stages, and stage k moves the word right by 2^k positions when bit k of the rotate amount is set.

Each stage does not pick one of two inputs. It steers its word onto exactly one of two outgoing paths, the moved path or the straight path, and it forces the other path to zero. The next level rebuilds the word by ORing the two paths. Because of this, the path not in use stays quiet.

A left shift by s is done as a right rotate by (N - s) mod N. The logical and arithmetic modes come from the rotated word: a mask picks the vacated positions, and those positions are overwritten with a fill value.

Operations arrive on a valid/ready input and leave on a valid/ready output. A single output register sits between them. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. The result stays on the output until the consumer takes it with `out_ready`. `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. So while the consumer holds back, the unit takes no new operation.

Top module: `fsr_shift_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0.
- R2: Mode 0 with `in_dir`=0 (right) rotates right by s = `in_amt`: output bit i equals input bit (i+s) mod N.
- R3: Mode 0 with `in_dir`=1 (left) rotates left by s: output bit i equals input bit (i-s) mod N.
- R4: Mode 1 (logical) with right direction gives output bit i = input bit i+s when i+s < N. The top s bits are 0.
- R5: Mode 2 (arithmetic) with right direction gives output bit i = input bit i+s when i+s < N. The top s bits are copies of input bit N-1.
- R6: Modes 1 and 2 with left direction give output bit i = input bit i-s when i >= s. The bottom s bits are 0.
- R7: A shift amount of 0 returns the input word unchanged, in every mode and direction.
- R8: Mode 3 behaves exactly like mode 0.
- R9: An operation accepted on an edge (`in_valid` and `in_ready` both high) appears with `out_valid`=1 after that edge.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold their values and `in_ready` is 0.
- R11: In every rotator stage, at least one of the two outgoing paths is all zeros: the moved path when the stage's amount bit is 0, and the straight path when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | N | Word to shift |
| in_amt | input | log2(N) | Shift amount s |
| in_dir | input | 1 | 0 = right, 1 = left |
| in_mode | input | 2 | 0 rotate, 1 logical, 2 arithmetic, 3 rotate |
| out_valid | output | 1 | Result held on out_data |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N | Shifted word |

## Verification
At N=8 the bench applies every 8-bit word with every amount, both directions and all four modes. Every stage is exercised both active and idle.

The two rotate directions are told apart by the source bit of each output position. The two shift modes are told apart only by words whose top bit is set. Amount 0 and amount N-1 bound the masks: one gives an empty mask, the other a full mask less one bit.

A stall sequence offers a second operation while the output is held. This shows that nothing is lost and nothing is overwritten.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHF_ROT = 2'd0,
    SHF_LOG = 2'd1,
    SHF_ARI = 2'd2,
    SHF_RSV = 2'd3
  } shf_mode_e;

  // Right is 0, left is 1
  localparam logic DIR_RIGHT = 1'b0;
  localparam logic DIR_LEFT  = 1'b1;

endpackage

// File: rtl/fsr_stage.sv
// One rotator level: steers the word onto exactly one of two paths.
module fsr_stage #(
  parameter int N    = 32,
  parameter int DIST = 1
) (
  input  logic [N-1:0] d_i,
  input  logic         sel_i,
  output logic [N-1:0] moved_o,
  output logic [N-1:0] stay_o
);

  localparam int D = DIST % N;

  logic [N-1:0] rot_w;

  // Fixed wiring: right rotate by DIST
  for (genvar i = 0; i < N; i++) begin : g_wire
    assign rot_w[i] = d_i[(i + D) % N];
  end

  // Demultiplex: the unused path is forced quiet
  assign moved_o = rot_w & {N{sel_i}};
  assign stay_o  = d_i   & {N{~sel_i}};

endmodule

// File: rtl/fsr_rotator.sv
// Logarithmic right rotator built from fanout-split stages.
module fsr_rotator #(
  parameter int N   = 32,
  parameter int STG = $clog2(N)
) (
  input  logic [N-1:0]           data_i,
  input  logic [STG-1:0]         amt_i,
  output logic [STG-1:0][N-1:0]  moved_o,
  output logic [STG-1:0][N-1:0]  stay_o,
  output logic [N-1:0]           data_o
);

  logic [STG:0][N-1:0] lvl;

  assign lvl[0] = data_i;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    fsr_stage #(
      .N    (N),
      .DIST (1 << k)
    ) u_stage (
      .d_i     (lvl[k]),
      .sel_i   (amt_i[k]),
      .moved_o (moved_o[k]),
      .stay_o  (stay_o[k])
    );
    // Merge: only one path carries data, so OR rebuilds the word
    assign lvl[k+1] = moved_o[k] | stay_o[k];
  end

  assign data_o = lvl[STG];

endmodule

// File: rtl/fsr_mask.sv
// Vacated-position mask and fill value for the non-rotate modes.
module fsr_mask #(
  parameter int N  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0]         amt_i,
  input  logic                  dir_i,
  input  shf_pkg::shf_mode_e    mode_i,
  input  logic                  sign_i,
  output logic [N-1:0]          mask_o,
  output logic                  fill_o
);
  import shf_pkg::*;

  logic is_shift;
  int   amt_int;

  assign is_shift = (mode_i == SHF_LOG) || (mode_i == SHF_ARI);
  assign amt_int  = int'(amt_i);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!is_shift) begin
        mask_o[i] = 1'b0;
      end else if (dir_i == DIR_LEFT) begin
        mask_o[i] = (i < amt_int);
      end else begin
        mask_o[i] = (i >= (N - amt_int));
      end
    end
  end

  assign fill_o = (mode_i == SHF_ARI) && (dir_i == DIR_RIGHT) && sign_i;

endmodule

// File: rtl/fsr_shift_unit.sv
// Top: rotate/logical/arithmetic shifter with a registered stream output.
module fsr_shift_unit #(
  parameter int N = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N-1:0]            in_data,
  input  logic [$clog2(N)-1:0]    in_amt,
  input  logic                    in_dir,
  input  logic [1:0]              in_mode,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [N-1:0]            out_data
);
  import shf_pkg::*;

  localparam int AW = $clog2(N);

  shf_mode_e             mode_w;
  logic [AW-1:0]         rot_amt;
  logic [AW-1:0]         neg_amt;
  logic [AW-1:0][N-1:0]  moved_w;
  logic [AW-1:0][N-1:0]  stay_w;
  logic [N-1:0]          rot_w;
  logic [N-1:0]          mask_w;
  logic                  fill_w;
  logic [N-1:0]          result_w;
  logic                  take;

  assign mode_w  = shf_mode_e'(in_mode);
  // Left by s equals right by (N - s) mod N; AW bits wrap naturally
  assign neg_amt = AW'(0) - in_amt;
  assign rot_amt = (in_dir == DIR_LEFT) ? neg_amt : in_amt;

  fsr_rotator #(
    .N   (N),
    .STG (AW)
  ) u_rot (
    .data_i  (in_data),
    .amt_i   (rot_amt),
    .moved_o (moved_w),
    .stay_o  (stay_w),
    .data_o  (rot_w)
  );

  fsr_mask #(
    .N  (N),
    .AW (AW)
  ) u_mask (
    .amt_i  (in_amt),
    .dir_i  (in_dir),
    .mode_i (mode_w),
    .sign_i (in_data[N-1]),
    .mask_o (mask_w),
    .fill_o (fill_w)
  );

  assign result_w = (rot_w & ~mask_w) | ({N{fill_w}} & mask_w);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= result_w;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fsr_shift_unit_chk.sv
module fsr_shift_unit_chk #(
  parameter int N = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic [N-1:0]                   in_data,
  input logic [$clog2(N)-1:0]           in_amt,
  input logic                           in_dir,
  input logic [1:0]                     in_mode,
  input logic                           out_valid,
  input logic                           out_ready,
  input logic [N-1:0]                   out_data,
  input logic [$clog2(N)-1:0][N-1:0]    moved,
  input logic [$clog2(N)-1:0][N-1:0]    stay
);

  localparam int STG = $clog2(N);

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_amt == '0) |=> (out_data == $past(in_data)));

  // R5
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'd2 && !in_dir && in_data[N-1])
      |=> out_data[N-1]);

  for (genvar k = 0; k < STG; k++) begin : g_quiet
    // R11
    quiet_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (moved[k] == '0) || (stay[k] == '0));
  end

endmodule

bind fsr_shift_unit fsr_shift_unit_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_amt    (in_amt),
  .in_dir    (in_dir),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .moved     (moved_w),
  .stay      (stay_w)
);

// File: tb/fsr_shift_unit_bench.sv
module fsr_shift_unit_bench;

  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic          in_dir = 1'b0;
  logic [1:0]    in_mode = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [N-1:0]  out_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  fsr_shift_unit #(.N(N)) u_fsr_shift_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_amt    (in_amt),
    .in_dir    (in_dir),
    .in_mode   (in_mode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic logic [N-1:0] ref_fn(logic [N-1:0] d, int s, logic dir, int mode);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (mode == 1 || mode == 2) begin
        if (dir) r[i] = (i >= s) ? d[i-s] : 1'b0;
        else     r[i] = (i + s < N) ? d[i+s] : ((mode == 2) ? d[N-1] : 1'b0);
      end else begin
        if (dir) r[i] = d[(i - s + N) % N];
        else     r[i] = d[(i + s) % N];
      end
    end
    return r;
  endfunction

  function automatic string tag_fn(int s, logic dir, int mode);
    if (s == 0)    return "R7";
    if (mode == 3) return "R8";
    if (mode == 0) return dir ? "R3" : "R2";
    if (dir)       return "R6";
    return (mode == 2) ? "R5" : "R4";
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [N-1:0] d, int s, logic dir, int mode);
    @(negedge clk);
    in_data  = d;
    in_amt   = AW'(s);
    in_dir   = dir;
    in_mode  = 2'(mode);
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R9: result registered one edge after acceptance
    check("R9", N'(out_valid), N'(1));
    // R11: a non-quiet idle path would corrupt the OR merge and show here
    check(tag_fn(s, dir, mode), out_data, ref_fn(d, s, dir, mode));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1", N'(out_valid), N'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", N'(out_valid), N'(0));

    for (int mode = 0; mode < 4; mode++)
      for (int dir = 0; dir < 2; dir++)
        for (int s = 0; s < N; s++)
          for (int d = 0; d < 256; d++)
            run_op(N'(d), s, dir[0], mode);

    // R10: stall with a competing offer
    @(negedge clk);
    in_data = 8'hA5; in_amt = 3'd1; in_dir = 1'b0; in_mode = 2'd0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    held = out_data;
    check("R10", held, ref_fn(8'hA5, 1, 1'b0, 0));
    in_data = 8'h3C; in_amt = 3'd2;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R10", N'(out_valid), N'(1));
      check("R10", out_data, held);
      check("R10", N'(in_ready), N'(0));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // second offer taken on the release edge
    check("R10", out_data, ref_fn(8'h3C, 2, 1'b0, 0));
    @(negedge clk);
    check("R9", N'(out_valid), N'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule